// File: doc/BRIEF.md
# Snooping Coherence Line-State Controller

This block keeps the coherence state of every line in a small private cache that sits on a shared snooping bus. The cache writes back and invalidates on writes. Each line holds one of five states: invalid, shared, exclusive-clean, owned or modified. The processor side issues load, store and evict requests against a line index. The block answers each request in the same cycle. It decides whether the request completes locally, needs a bus request (read, read-for-ownership or upgrade) or needs a write-back of dirty data.

The snoop side presents bus requests made by other caches. For each one the block drives the wired-OR "copy present" and "dirty copy present" lines. It also says whether this cache must supply the data, and it moves the local line to its new state. Bus transactions are atomic. The bus request, the sampled shared line and the state change all belong to one clock cycle, so no transient states exist.

Data arrays, tag matching, victim choice and bus arbitration belong to the surrounding cache. This block sees only line indices and operations.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads back as invalid. The state codes on `cpu_state` are invalid=0, shared=1, exclusive=2, owned=3, modified=4.
- R2: A load (cpu_op=0) to a valid line completes with no bus request, and the state does not change. A load to an invalid line issues a bus read (bus_req_op=0). The line then becomes exclusive if `bus_shared_in` is low in that cycle, and shared if it is high.
- R3: A store (cpu_op=1) to an invalid line issues a read-for-ownership (bus_req_op=1), and the line becomes modified.
- R4: A store to a shared or owned line issues only an upgrade (bus_req_op=2), and the line becomes modified.
- R5: A store to an exclusive line becomes modified with no bus request. A store to a modified line stays modified with no bus request.
- R6: An evict (cpu_op=2) of a modified or owned line raises `wb_req` and leaves the line invalid. An evict of an exclusive or shared line is silent and leaves it invalid. An evict of an invalid line does nothing visible.
- R7: A snooped read (snp_op=0) to any valid line raises `snp_shared_out`. A snoop to an invalid line raises none of the snoop outputs.
- R8: A snooped read moves modified to owned and exclusive to shared, and leaves shared and owned unchanged. It raises `snp_supply` when the line was modified or owned.
- R9: A snooped read-for-ownership (snp_op=1) or upgrade (snp_op=2) leaves the line invalid. A read-for-ownership raises `snp_supply` if the line was modified or owned. An upgrade never does.
- R10: `snp_dirty_out` is high for any snoop (snp_op 0 to 2) whose line is modified or owned, and only then.
- R11: When a snoop and a processor request name the same index in one cycle, the snoop wins. `cpu_done`, `bus_req_valid` and `wb_req` stay low, and the line takes only the snoop's next state.
- R12: A snoop and a processor request on different indices both take effect in the same cycle. Operation code 3 on either side is ignored: it changes no state and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict, 3 ignored |
| cpu_idx | input | IDX_W | Line index of processor request, also selects `cpu_state` |
| cpu_done | output | 1 | Processor request accepted this cycle |
| cpu_state | output | 3 | Current state of line `cpu_idx` |
| bus_req_valid | output | 1 | Bus request issued for the processor request |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade |
| bus_shared_in | input | 1 | Wired-OR copy-present line sampled on a read miss |
| wb_req | output | 1 | Dirty line must be written back |
| snp_valid | input | 1 | Snooped bus request present |
| snp_op | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 ignored |
| snp_idx | input | IDX_W | Line index of snooped request |
| snp_shared_out | output | 1 | Drive of wired-OR copy-present line |
| snp_dirty_out | output | 1 | Drive of wired-OR dirty line, memory must not respond |
| snp_supply | output | 1 | This cache supplies the snooped data |

## Verification
A wrong stored state shows up on the next access to that line. A bad state makes a load or store issue a needless bus request, or skip a needed one. It can also make an evict lose a write-back, or make a snoop drive the wrong shared, dirty or supply lines. The bench drives each of the five states into place through the ports, then applies every processor and snoop operation to it. It checks the combinational response in the same cycle and reads `cpu_state` back one cycle later. Any state error therefore shows within one cycle of the transition that caused it.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHR = 3'd1,
    LS_EXC = 3'd2,
    LS_OWN = 3'd3,
    LS_MOD = 3'd4
  } lstate_e;

  typedef enum logic [1:0] {
    CP_LOAD  = 2'd0,
    CP_STORE = 2'd1,
    CP_EVICT = 2'd2,
    CP_NOP   = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    BO_READ = 2'd0,
    BO_RDX  = 2'd1,
    BO_UPG  = 2'd2,
    BO_NONE = 2'd3
  } bus_op_e;
endpackage

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
(
  input  lstate_e cur,
  input  cpu_op_e op,
  input  logic    shared_in,
  output lstate_e nxt,
  output logic    bus_v,
  output bus_op_e bus_op,
  output logic    wb
);
  always_comb begin
    nxt    = cur;
    bus_v  = 1'b0;
    bus_op = BO_NONE;
    wb     = 1'b0;
    unique case (op)
      CP_LOAD: begin
        if (cur == LS_INV) begin
          bus_v  = 1'b1;
          bus_op = BO_READ;
          nxt    = shared_in ? LS_SHR : LS_EXC;
        end
      end
      CP_STORE: begin
        nxt = LS_MOD;
        if (cur == LS_INV) begin
          bus_v  = 1'b1;
          bus_op = BO_RDX;
        end else if (cur == LS_SHR || cur == LS_OWN) begin
          bus_v  = 1'b1;
          bus_op = BO_UPG;
        end
      end
      CP_EVICT: begin
        wb  = (cur == LS_MOD) || (cur == LS_OWN);
        nxt = LS_INV;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
  import coh_pkg::*;
(
  input  lstate_e cur,
  input  bus_op_e op,
  output lstate_e nxt,
  output logic    shared_o,
  output logic    dirty_o,
  output logic    supply_o
);
  logic valid_line;
  logic dirty_line;

  assign valid_line = (cur != LS_INV);
  assign dirty_line = (cur == LS_MOD) || (cur == LS_OWN);

  always_comb begin
    nxt      = cur;
    shared_o = 1'b0;
    dirty_o  = 1'b0;
    supply_o = 1'b0;
    unique case (op)
      BO_READ: begin
        shared_o = valid_line;
        dirty_o  = dirty_line;
        supply_o = dirty_line;
        if (cur == LS_MOD)      nxt = LS_OWN;
        else if (cur == LS_EXC) nxt = LS_SHR;
      end
      BO_RDX: begin
        dirty_o  = dirty_line;
        supply_o = dirty_line;
        nxt      = LS_INV;
      end
      BO_UPG: begin
        dirty_o = dirty_line;
        nxt     = LS_INV;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic [1:0]       cpu_op,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic             cpu_done,
  output logic [2:0]       cpu_state,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_op,
  input  logic             bus_shared_in,
  output logic             wb_req,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_shared_out,
  output logic             snp_dirty_out,
  output logic             snp_supply
);
  lstate_e st_q [LINES];

  cpu_op_e cop;
  bus_op_e sop;
  lstate_e cpu_cur, snp_cur, cpu_nxt, snp_nxt;
  logic    c_bus_v, c_wb;
  bus_op_e c_bus_op;
  logic    s_sh, s_dirty, s_sup;
  logic    snp_act, collide, cpu_fire;

  assign cop      = cpu_op_e'(cpu_op);
  assign sop      = bus_op_e'(snp_op);
  assign cpu_cur  = st_q[cpu_idx];
  assign snp_cur  = st_q[snp_idx];
  assign snp_act  = snp_valid && (sop != BO_NONE);
  assign collide  = snp_act && (snp_idx == cpu_idx);
  assign cpu_fire = cpu_valid && (cop != CP_NOP) && !collide;

  coh_cpu_fsm u_cpu (
    .cur      (cpu_cur),
    .op       (cop),
    .shared_in(bus_shared_in),
    .nxt      (cpu_nxt),
    .bus_v    (c_bus_v),
    .bus_op   (c_bus_op),
    .wb       (c_wb)
  );

  coh_snoop_fsm u_snp (
    .cur     (snp_cur),
    .op      (sop),
    .nxt     (snp_nxt),
    .shared_o(s_sh),
    .dirty_o (s_dirty),
    .supply_o(s_sup)
  );

  assign cpu_done       = cpu_fire;
  assign cpu_state      = cpu_cur;
  assign bus_req_valid  = cpu_fire && c_bus_v;
  assign bus_req_op     = c_bus_op;
  assign wb_req         = cpu_fire && c_wb;
  assign snp_shared_out = snp_act && s_sh;
  assign snp_dirty_out  = snp_act && s_dirty;
  assign snp_supply     = snp_act && s_sup;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    lstate_e st_d;
    logic    st_en;

    always_comb begin
      st_en = 1'b0;
      st_d  = st_q[i];
      if (snp_act && (snp_idx == IDX_W'(i))) begin
        st_en = 1'b1;
        st_d  = snp_nxt;
      end else if (cpu_fire && (cpu_idx == IDX_W'(i))) begin
        st_en = 1'b1;
        st_d  = cpu_nxt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[i] <= LS_INV;
      else if (st_en) st_q[i] <= st_d;
    end
  end

  // R2: a read miss fills according to the sampled shared line
  a_r2_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fire && cop == CP_LOAD && cpu_cur == LS_INV)
    |=> st_q[$past(cpu_idx)] == ($past(bus_shared_in) ? LS_SHR : LS_EXC));

  // R5: exclusive store upgrades without any bus traffic
  a_r5_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fire && cop == CP_STORE && cpu_cur == LS_EXC) |-> !bus_req_valid);

  // R6: a write-back leaves the line invalid
  a_r6_wb_leaves_inv: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> st_q[$past(cpu_idx)] == LS_INV);

  // R8: snooped read of a modified line keeps ownership of dirty data
  a_r8_mod_to_own: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_act && sop == BO_READ && snp_cur == LS_MOD)
    |=> st_q[$past(snp_idx)] == LS_OWN);

  // R9: exclusive-intent snoops invalidate the local copy
  a_r9_snoop_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_act && (sop == BO_RDX || sop == BO_UPG))
    |=> st_q[$past(snp_idx)] == LS_INV);

  // R10: supplying data always comes with the dirty indication
  a_r10_supply_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_dirty_out);

  // R11: same-index collision blocks the processor side
  a_r11_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_act && cpu_valid && snp_idx == cpu_idx)
    |-> (!cpu_done && !bus_req_valid && !wb_req));
endmodule

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;
  localparam int LINES = 8;
  localparam int IW = 3;

  logic clk, rst_n;
  logic cpu_valid; logic [1:0] cpu_op; logic [IW-1:0] cpu_idx;
  logic cpu_done; logic [2:0] cpu_state;
  logic bus_req_valid; logic [1:0] bus_req_op; logic bus_shared_in; logic wb_req;
  logic snp_valid; logic [1:0] snp_op; logic [IW-1:0] snp_idx;
  logic snp_shared_out, snp_dirty_out, snp_supply;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  coh_line_ctrl #(.LINES(LINES)) dut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  // sampled outputs
  int o_done, o_bv, o_bop, o_wb, o_sh, o_dt, o_sup;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic apply(input bit cv, input int cop, input int cidx, input bit sh,
                       input bit sv, input int sop, input int sidx);
    @(negedge clk);
    cpu_valid = cv; cpu_op = 2'(cop); cpu_idx = IW'(cidx); bus_shared_in = sh;
    snp_valid = sv; snp_op = 2'(sop); snp_idx = IW'(sidx);
    #3;
    o_done = cpu_done; o_bv = bus_req_valid; o_bop = bus_req_op; o_wb = wb_req;
    o_sh = snp_shared_out; o_dt = snp_dirty_out; o_sup = snp_supply;
    @(posedge clk); #1;
    cpu_valid = 0; snp_valid = 0;
  endtask

  task automatic read_state(input int idx, output int st);
    @(negedge clk);
    cpu_valid = 0; snp_valid = 0; cpu_idx = IW'(idx);
    #1 st = cpu_state;
  endtask

  // bring line idx into state s using ports only
  task automatic setup(input int idx, input int s);
    apply(1, 2, idx, 0, 0, 3, 0);
    case (s)
      1: apply(1, 0, idx, 1, 0, 3, 0);
      2: apply(1, 0, idx, 0, 0, 3, 0);
      3: begin apply(1, 1, idx, 0, 0, 3, 0); apply(0, 3, idx, 0, 1, 0, idx); end
      4: apply(1, 1, idx, 0, 0, 3, 0);
      default: ;
    endcase
  endtask

  // expected processor-side response from the requirement tables
  function automatic void exp_cpu(input int s, input int op, input bit sh,
      output int done, output int bv, output int bop, output int wb, output int nx);
    done = (op != 3); bv = 0; bop = 0; wb = 0; nx = s;
    case (op)
      0: if (s == 0) begin bv = 1; bop = 0; nx = sh ? 1 : 2; end
      1: begin
        nx = 4;
        if (s == 0) begin bv = 1; bop = 1; end
        else if (s == 1 || s == 3) begin bv = 1; bop = 2; end
      end
      2: begin wb = (s == 3 || s == 4); nx = 0; end
      default: ;
    endcase
  endfunction

  function automatic void exp_snp(input int s, input int op,
      output int sh, output int dt, output int sup, output int nx);
    bit dirty = (s == 3 || s == 4);
    sh = (op == 0) && (s != 0);
    dt = (op != 3) && dirty;
    sup = dt && (op != 2);
    nx = s;
    if (op == 0) begin
      if (s == 4) nx = 3;
      else if (s == 2) nx = 1;
    end else if (op != 3) nx = 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int st;
    int e_done, e_bv, e_bop, e_wb, e_nx, e_sh, e_dt, e_sup;
    int n;
    cpu_valid = 0; cpu_op = 0; cpu_idx = 0; bus_shared_in = 0;
    snp_valid = 0; snp_op = 3; snp_idx = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1: reset state of every line
    for (int i = 0; i < LINES; i++) begin
      read_state(i, st);
      chk("R1 reset state", st, 0);
    end

    // R2..R6, R12: processor sweep over state x op x shared
    n = 0;
    for (int s = 0; s < 5; s++)
      for (int op = 0; op < 4; op++)
        for (int sh = 0; sh < 2; sh++) begin
          int idx = n % LINES;
          string tag;
          n++;
          tag = (op == 0) ? "R2" : (op == 1) ? ((s == 0) ? "R3" : (s == 1 || s == 3) ? "R4" : "R5")
              : (op == 2) ? "R6" : "R12";
          setup(idx, s);
          exp_cpu(s, op, sh[0], e_done, e_bv, e_bop, e_wb, e_nx);
          apply(1, op, idx, sh[0], 0, 3, 0);
          chk({tag, " cpu_done"}, o_done, e_done);
          chk({tag, " bus_req_valid"}, o_bv, e_bv);
          if (e_bv != 0) chk({tag, " bus_req_op"}, o_bop, e_bop);
          chk({tag, " wb_req"}, o_wb, e_wb);
          read_state(idx, st);
          chk({tag, " next state"}, st, e_nx);
        end

    // R7..R10, R12: snoop sweep over state x op
    for (int s = 0; s < 5; s++)
      for (int op = 0; op < 4; op++) begin
        int idx = (s + op) % LINES;
        string tag;
        tag = (op == 0) ? "R8" : (op == 3) ? "R12" : "R9";
        setup(idx, s);
        exp_snp(s, op, e_sh, e_dt, e_sup, e_nx);
        apply(0, 3, 0, 0, 1, op, idx);
        chk("R7 snp_shared_out", o_sh, e_sh);
        chk("R10 snp_dirty_out", o_dt, e_dt);
        chk({tag, " snp_supply"}, o_sup, e_sup);
        read_state(idx, st);
        chk({tag, " snoop next state"}, st, e_nx);
      end

    // R11: store and snooped read-for-ownership on the same shared line
    setup(3, 1);
    apply(1, 1, 3, 0, 1, 1, 3);
    chk("R11 collide cpu_done", o_done, 0);
    chk("R11 collide bus_req_valid", o_bv, 0);
    read_state(3, st);
    chk("R11 collide state", st, 0);

    // R11: evict and snooped read on the same modified line
    setup(4, 4);
    apply(1, 2, 4, 0, 1, 0, 4);
    chk("R11 collide wb_req", o_wb, 0);
    chk("R11 collide supply", o_sup, 1);
    read_state(4, st);
    chk("R11 collide owned", st, 3);

    // R12: different indices both take effect
    setup(1, 4);
    setup(2, 2);
    apply(1, 1, 2, 0, 1, 0, 1);
    chk("R12 parallel cpu_done", o_done, 1);
    chk("R12 parallel bus_req_valid", o_bv, 0);
    chk("R12 parallel dirty", o_dt, 1);
    read_state(2, st);
    chk("R12 parallel cpu line", st, 4);
    read_state(1, st);
    chk("R12 parallel snoop line", st, 3);

    finish_run();
  end
endmodule